// File: doc/BRIEF.md
# Bit Scan and Zero Count Unit

This execution unit takes one integer operand of 16, 32 or 64 bits and returns either a bit position or a count of zero bits. A direction input picks the family. When it is 0 the unit either finds the lowest set bit or counts trailing zeros. When it is 1 it either finds the highest set bit or counts leading zeros. Counting is used only when a repeat-prefix input is high and the feature enable that belongs to that family is also high. In every other case the unit does a plain bit scan.

The two modes share one pair of zero counters. In scan mode an all-zero operand leaves the destination unchanged: the incoming destination value is passed to the result. In count mode an all-zero operand yields the operand width. The unit also produces a zero flag and a carry flag, plus a mask that says which of the two flags are defined. Inputs are captured on each clock edge and every output is registered, so the latency is one cycle.

Top module: `bsc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `result`=0, `zf`=0, `cf`=0 and `flag_vld`=0.
- R2: Outputs are registered. The values seen after an edge are computed from the inputs sampled at that edge, and a new operation can be issued on every cycle.
- R3: Count mode is selected when `rep_pfx`=1 and the matching enable is 1: `lead_en` when `rev`=1, `trail_en` when `rev`=0. Otherwise scan mode is used. `flag_vld` bit 0 marks `zf` as defined and bit 1 marks `cf` as defined: it reads 2'b11 in count mode and 2'b01 in scan mode.
- R4: The `size_sel` encoding is 2'b00 for 16 bits, 2'b01 for 32 bits, and 2'b10 or 2'b11 for 64 bits. Operand bits at or above the selected width have no effect on any output.
- R5: A forward scan of a nonzero operand returns the index of its lowest set bit.
- R6: A reverse scan of a nonzero operand returns the index of its highest set bit.
- R7: A scan in either direction of an all-zero operand returns `dst_in` unchanged, all 64 bits.
- R8: In scan mode, `zf`=1 exactly when the operand within its width is zero, and `cf`=0.
- R9: A trailing count returns the number of zero bits below the lowest set bit. It returns the operand width (16, 32 or 64) when the operand is zero.
- R10: A leading count returns the number of zero bits between the top bit of the selected width and the highest set bit. It returns the operand width when the operand is zero.
- R11: In count mode, `cf`=1 exactly when the operand is zero and `zf`=1 exactly when the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd | input | 64 | Source operand |
| size_sel | input | 2 | Operand width select |
| rev | input | 1 | Direction: 0 lowest-bit family, 1 highest-bit family |
| rep_pfx | input | 1 | Repeat prefix present |
| lead_en | input | 1 | Leading-count feature enable |
| trail_en | input | 1 | Trailing-count feature enable |
| dst_in | input | 64 | Current destination value |
| result | output | 64 | Value to write back |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry flag |
| flag_vld | output | 2 | Defined-flag mask (bit 1 carry, bit 0 zero) |

## Verification
On every cycle, properties check the following:
- the mode mask that follows from the prefix and enable inputs;
- the passing through of the destination on an all-zero scan;
- that carry is clear whenever only zero is marked valid;
- the agreement of zero with a zero count;
- the width result and carry for an all-zero operand in count mode;
- that no count exceeds the operand width.

The exact bit positions and counts need the bench's scenarios. These cover single-bit, top-bit, all-ones and mixed operands at each width, garbage above the selected width, and enable combinations that fall back to scanning. All of them are compared against a loop-based model.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [1:0] {
    SZ_QTR  = 2'b00,
    SZ_HALF = 2'b01,
    SZ_FULL = 2'b10,
    SZ_ALT  = 2'b11
  } size_e;

  typedef struct packed {
    logic       zf;
    logic       cf;
    logic [1:0] vld;
  } flags_t;

  localparam logic [1:0] VLD_SCAN  = 2'b01;
  localparam logic [1:0] VLD_COUNT = 2'b11;

endpackage

// File: rtl/bsc_prep.sv
module bsc_prep
  import bsc_pkg::*;
#(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input  logic [W-1:0]  opnd,
  input  logic [1:0]    size_sel,
  output logic [W-1:0]  ext,
  output logic [W-1:0]  filled,
  output logic [CW-1:0] size_cnt,
  output logic          is_zero
);

  localparam int WQ = W / 4;
  localparam int WH = W / 2;

  logic [W-1:0] keep;

  always_comb begin
    case (size_sel)
      SZ_QTR: begin
        keep     = {{(W-WQ){1'b0}}, {WQ{1'b1}}};
        size_cnt = CW'(WQ);
      end
      SZ_HALF: begin
        keep     = {{(W-WH){1'b0}}, {WH{1'b1}}};
        size_cnt = CW'(WH);
      end
      default: begin
        keep     = '1;
        size_cnt = CW'(W);
      end
    endcase
  end

  // zero-extend, then fill above the width so a trailing count stops at the width
  assign ext     = opnd & keep;
  assign filled  = ext | ~keep;
  assign is_zero = (ext == '0);

endmodule

// File: rtl/bsc_lzc.sv
module bsc_lzc #(
  parameter int W  = 64,
  parameter int G  = 4,
  parameter int CW = 7
) (
  input  logic [W-1:0]  v,
  output logic [CW-1:0] cnt
);

  localparam int N  = W / G;
  localparam int GW = $clog2(G + 1);

  logic [N-1:0][GW-1:0] gcnt;
  logic [N-1:0]         gzero;

  // group 0 holds the most significant bits
  for (genvar g = 0; g < N; g++) begin : g_grp
    logic [G-1:0]  bits;
    logic [GW-1:0] gc;

    assign bits = v[W-1-g*G -: G];

    always_comb begin
      gc = GW'(G);
      for (int b = 0; b < G; b++) begin
        if (bits[b]) gc = GW'(G - 1 - b);
      end
    end

    assign gcnt[g]  = gc;
    assign gzero[g] = ~|bits;
  end

  logic [CW-1:0] acc;
  logic          stop;

  always_comb begin
    acc  = '0;
    stop = 1'b0;
    for (int g = 0; g < N; g++) begin
      if (!stop) begin
        acc  = acc + CW'(gcnt[g]);
        stop = ~gzero[g];
      end
    end
  end

  assign cnt = acc;

endmodule

// File: rtl/bsc_sel.sv
module bsc_sel
  import bsc_pkg::*;
#(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input  logic          rev,
  input  logic          rep_pfx,
  input  logic          lead_en,
  input  logic          trail_en,
  input  logic [CW-1:0] lz_cnt,
  input  logic [CW-1:0] tz_cnt,
  input  logic [CW-1:0] size_cnt,
  input  logic          is_zero,
  input  logic [W-1:0]  dst_in,
  output logic [W-1:0]  res,
  output flags_t        flg
);

  logic          count_mode;
  logic [CW-1:0] lead_cnt;
  logic [CW-1:0] cnt_val;

  assign count_mode = rep_pfx & (rev ? lead_en : trail_en);
  // the full-width leading count includes the zeros above the operand width
  assign lead_cnt   = lz_cnt - (CW'(W) - size_cnt);
  assign cnt_val    = rev ? lead_cnt : tz_cnt;

  always_comb begin
    if (count_mode) begin
      res     = W'(cnt_val);
      flg.cf  = is_zero;
      flg.zf  = (cnt_val == '0);
      flg.vld = VLD_COUNT;
    end else begin
      flg.cf  = 1'b0;
      flg.zf  = is_zero;
      flg.vld = VLD_SCAN;
      if (is_zero)  res = dst_in;
      else if (rev) res = W'(lz_cnt ^ CW'(W - 1));
      else          res = W'(tz_cnt);
    end
  end

endmodule

// File: rtl/bsc_unit.sv
module bsc_unit
  import bsc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int GRP_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opnd,
  input  logic [1:0]        size_sel,
  input  logic              rev,
  input  logic              rep_pfx,
  input  logic              lead_en,
  input  logic              trail_en,
  input  logic [DATA_W-1:0] dst_in,
  output logic [DATA_W-1:0] result,
  output logic              zf,
  output logic              cf,
  output logic [1:0]        flag_vld
);

  localparam int CNT_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] ext, filled, filled_rev, res_d;
  logic [CNT_W-1:0]  size_cnt, lz_cnt, tz_cnt;
  logic              is_zero;
  flags_t            flg_d;

  bsc_prep #(.W(DATA_W), .CW(CNT_W)) u_prep (
    .opnd     (opnd),
    .size_sel (size_sel),
    .ext      (ext),
    .filled   (filled),
    .size_cnt (size_cnt),
    .is_zero  (is_zero)
  );

  // the trailing count is a leading count of the bit-reversed word
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign filled_rev[i] = filled[DATA_W-1-i];
  end

  bsc_lzc #(.W(DATA_W), .G(GRP_W), .CW(CNT_W)) u_lz (
    .v   (ext),
    .cnt (lz_cnt)
  );

  bsc_lzc #(.W(DATA_W), .G(GRP_W), .CW(CNT_W)) u_tz (
    .v   (filled_rev),
    .cnt (tz_cnt)
  );

  bsc_sel #(.W(DATA_W), .CW(CNT_W)) u_sel (
    .rev      (rev),
    .rep_pfx  (rep_pfx),
    .lead_en  (lead_en),
    .trail_en (trail_en),
    .lz_cnt   (lz_cnt),
    .tz_cnt   (tz_cnt),
    .size_cnt (size_cnt),
    .is_zero  (is_zero),
    .dst_in   (dst_in),
    .res      (res_d),
    .flg      (flg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      zf       <= 1'b0;
      cf       <= 1'b0;
      flag_vld <= 2'b00;
    end else begin
      result   <= res_d;
      zf       <= flg_d.zf;
      cf       <= flg_d.cf;
      flag_vld <= flg_d.vld;
    end
  end

endmodule

// File: rtl/bsc_unit_chk.sv
module bsc_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] opnd,
  input logic [1:0]        size_sel,
  input logic              rev,
  input logic              rep_pfx,
  input logic              lead_en,
  input logic              trail_en,
  input logic [DATA_W-1:0] dst_in,
  input logic [DATA_W-1:0] result,
  input logic              zf,
  input logic              cf,
  input logic [1:0]        flag_vld
);

  function automatic logic [DATA_W-1:0] width_of(input logic [1:0] s);
    if (s == 2'b00)      width_of = DATA_W'(DATA_W / 4);
    else if (s == 2'b01) width_of = DATA_W'(DATA_W / 2);
    else                 width_of = DATA_W'(DATA_W);
  endfunction

  function automatic logic [DATA_W-1:0] lowmask(input logic [1:0] s);
    if (s == 2'b00)      lowmask = {{(DATA_W-DATA_W/4){1'b0}}, {(DATA_W/4){1'b1}}};
    else if (s == 2'b01) lowmask = {{(DATA_W-DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};
    else                 lowmask = '1;
  endfunction

  logic want_cnt, in_zero;
  assign want_cnt = rep_pfx && (rev ? lead_en : trail_en);
  assign in_zero  = ((opnd & lowmask(size_sel)) == '0);

  // R3
  cnt_mask_chk: assert property (@(posedge clk) disable iff (rst)
    want_cnt |=> (flag_vld == 2'b11));

  // R3
  scan_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !want_cnt |=> (flag_vld == 2'b01));

  // R7
  scan_keep_dst_chk: assert property (@(posedge clk) disable iff (rst)
    (!want_cnt && in_zero) |=> (result == $past(dst_in)));

  // R8
  scan_cf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_vld == 2'b01) |-> !cf);

  // R11
  cnt_zf_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_vld == 2'b11) |-> (zf == (result == '0)));

  // R11
  cnt_zero_in_chk: assert property (@(posedge clk) disable iff (rst)
    (want_cnt && in_zero) |=> (cf && result == width_of($past(size_sel))));

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    want_cnt |=> (result <= width_of($past(size_sel))));

endmodule

bind bsc_unit bsc_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bsc_unit_bench.sv
`timescale 1ns/1ps
module bsc_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] opnd = '0;
  logic [1:0]  size_sel = '0;
  logic        rev = 1'b0, rep_pfx = 1'b0, lead_en = 1'b0, trail_en = 1'b0;
  logic [63:0] dst_in = '0;
  logic [63:0] result;
  logic        zf, cf;
  logic [1:0]  flag_vld;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  bsc_unit u_bsc_unit (
    .clk(clk), .rst(rst), .opnd(opnd), .size_sel(size_sel), .rev(rev),
    .rep_pfx(rep_pfx), .lead_en(lead_en), .trail_en(trail_en), .dst_in(dst_in),
    .result(result), .zf(zf), .cf(cf), .flag_vld(flag_vld)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model, written from the requirements
  task automatic model(input logic [63:0] x_in, input logic [1:0] s, input logic r,
                       input logic rp, input logic le, input logic te, input logic [63:0] d,
                       output logic [63:0] e_res, output logic e_zf, output logic e_cf,
                       output logic [1:0] e_vld, output string rtag, output string ftag);
    int w;
    int n;
    logic [63:0] x;
    bit cnt, found, garbage;
    w = (s == 2'b00) ? 16 : (s == 2'b01) ? 32 : 64;
    x = '0;
    garbage = 0;
    for (int i = 0; i < 64; i++) begin
      if (i < w) x[i] = x_in[i];
      else if (x_in[i]) garbage = 1;
    end
    cnt = rp && (r ? le : te);
    if (!cnt) begin
      e_zf = (x == 0); e_cf = 1'b0; e_vld = 2'b01; ftag = "R8";
      if (x == 0) begin e_res = d; rtag = "R7"; end
      else begin
        e_res = 0;
        for (int i = 0; i < w; i++) if (x[i]) begin
          if (r) e_res = 64'(i);
          else if (e_res == 0 && !x[0]) e_res = 64'(i);
        end
        if (!r && x[0]) e_res = 0;
        rtag = r ? "R6" : "R5";
      end
    end else begin
      n = 0; found = 0;
      if (r) begin
        for (int i = w - 1; i >= 0; i--) begin
          if (x[i]) found = 1;
          if (!found) n++;
        end
        rtag = "R10";
      end else begin
        for (int i = 0; i < w; i++) begin
          if (x[i]) found = 1;
          if (!found) n++;
        end
        rtag = "R9";
      end
      e_res = 64'(n); e_cf = (x == 0); e_zf = (n == 0); e_vld = 2'b11; ftag = "R11";
    end
    if (garbage) rtag = {"R4 ", rtag};
  endtask

  // drive at a falling edge, compare at the next falling edge (one register stage, R2)
  task automatic run(input logic [63:0] x, input logic [1:0] s, input logic r,
                     input logic rp, input logic le, input logic te, input logic [63:0] d);
    logic [63:0] e_res; logic e_zf, e_cf; logic [1:0] e_vld; string rt, ft;
    opnd = x; size_sel = s; rev = r; rep_pfx = rp; lead_en = le; trail_en = te; dst_in = d;
    model(x, s, r, rp, le, te, d, e_res, e_zf, e_cf, e_vld, rt, ft);
    @(negedge clk);
    chk({rt, " result (R2 timing)"}, result, e_res);
    chk({ft, " zf"}, 64'(zf), 64'(e_zf));
    chk({ft, " cf"}, 64'(cf), 64'(e_cf));
    chk("R3 flag_vld", 64'(flag_vld), 64'(e_vld));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 result", result, 64'h0);
    chk("R1 flags", {60'h0, zf, cf, flag_vld}, 64'h0);
    rst = 1'b0;

    for (int s = 0; s < 3; s++) begin
      for (int m = 0; m < 4; m++) begin
        int w;
        logic r, rp;
        logic [63:0] allw;
        w = (s == 0) ? 16 : (s == 1) ? 32 : 64;
        allw = (w == 64) ? '1 : ((64'h1 << w) - 1);
        r  = m[0];
        rp = m[1];
        run(64'h0, 2'(s), r, rp, 1'b1, 1'b1, 64'hDEAD_BEEF_0123_4567);
        run(allw, 2'(s), r, rp, 1'b1, 1'b1, 64'h5);
        run(64'h1, 2'(s), r, rp, 1'b1, 1'b1, 64'h5);
        run(64'h1 << (w - 1), 2'(s), r, rp, 1'b1, 1'b1, 64'h5);
        run(64'h0000_0000_0000_0810, 2'(s), r, rp, 1'b1, 1'b1, 64'h5);
        for (int k = 0; k < w; k += 5) run(64'h1 << k, 2'(s), r, rp, 1'b1, 1'b1, 64'h7);
        // R4: bits above the width must not matter
        run(~allw | 64'h0100, 2'(s), r, rp, 1'b1, 1'b1, 64'h9);
        run(~allw, 2'(s), r, rp, 1'b1, 1'b1, 64'hFFFF_0000_FFFF_0000);
      end
    end

    // R3: the feature enables are matched to the direction
    run(64'h0F00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 64'h11);
    run(64'h0F00, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 64'h11);
    run(64'h0F00, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 64'h11);
    run(64'h0, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 64'hCAFE);
    run(64'h8000_0000_0000_0000, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 64'h0);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] x;
      x = {$urandom, $urandom};
      if (i % 3 == 0) x = x & (x >> ($urandom % 40));
      run(x, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          {$urandom, $urandom});
    end

    // R1: reset again after activity
    rst = 1'b1;
    @(negedge clk);
    chk("R1 result", result, 64'h0);
    chk("R1 flags", {60'h0, zf, cf, flag_vld}, 64'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule